// File: doc/BRIEF.md
# Subchannel Burst Write Data Generator

This block produces the write data stream for one 32-bit subchannel once a write command has been decoded. A normal write passes beats from the incoming data lanes to the write buffer. It takes a beat only while the lanes mark their data valid. A pattern write ignores the lanes. It builds every beat inside the block from a one-byte fill register, with that byte repeated across all four byte lanes. A flag tells the outside that the lanes are not being driven.

A full burst has 16 beats, which is 64 bytes on a 32-bit path. A chopped burst stops after 8 beats. A pattern burst has the same number of beats as a normal burst of the same length. Every beat carries its index, and the final beat is flagged. The block runs one burst at a time. A command that arrives while a burst is running is refused and flagged, and the running burst continues unchanged. The fill register is loaded through a simple write port. It clears to zero at reset.

Top module: `wrdata_gen`

## Requirements
- R1: After reset, `busy`, `beat_valid`, `beat_last`, `lanes_idle` and `cmd_reject` are low and `fill_byte` reads 0x00.
- R2: An accepted command with `cmd_chop` low yields exactly 16 beats with indices 0 to 15 in order. The burst ends after index 15.
- R3: An accepted command with `cmd_chop` high yields exactly 8 beats with indices 0 to 7. `beat_last` is high only on index 7 for a chopped burst and only on index 15 for a full burst.
- R4: In a normal write (`cmd_fill` low), `beat_data` equals `lane_data` and a beat is issued in a cycle only when `lane_valid` is high. While `lane_valid` is low the index holds, and the burst does not end early.
- R5: In a pattern write (`cmd_fill` high), every beat is the fill byte repeated in all four byte lanes, whatever `lane_data` and `lane_valid` do. `lanes_idle` is high for the whole burst.
- R6: A pattern burst issues one beat per cycle, so it lasts 16 cycles for a full burst and 8 cycles for a chopped one, the same beat count as a normal write.
- R7: A `cmd_valid` that arrives while `busy` is high gives `cmd_reject` in the same cycle. It has no effect on the running burst, and nothing is queued.
- R8: `fill_we` loads `fill_wdata` into `fill_byte` on the next edge. A pattern burst uses the value held when its command was accepted, even if the register is written during the burst.
- R9: A command taken while idle raises `busy` on the next cycle, and beat 0 can appear in that cycle. `busy` falls in the cycle after `beat_last`, and a new command can be accepted in that idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Write command strobe |
| cmd_fill | input | 1 | 1: pattern write, 0: normal write |
| cmd_chop | input | 1 | 1: 8-beat burst, 0: 16-beat burst |
| lane_data | input | 32 | Incoming data from the lanes |
| lane_valid | input | 1 | Lane data valid |
| fill_we | input | 1 | Fill register write enable |
| fill_wdata | input | 8 | Fill register write value |
| fill_byte | output | 8 | Current fill register value |
| beat_valid | output | 1 | A beat is issued this cycle |
| beat_data | output | 32 | Beat data to the write buffer |
| beat_idx | output | 4 | Index of the current beat |
| beat_last | output | 1 | Final beat of the burst |
| lanes_idle | output | 1 | Pattern burst running, lanes not used |
| busy | output | 1 | Burst running |
| cmd_reject | output | 1 | Command refused because a burst is running |

## Verification
A beat counter that skips or repeats an index shows up on `beat_idx` in the very next valid beat. It also moves `beat_last` away from index 7 or 15, so the burst either overruns or ends short, and `busy` makes this visible one cycle later. A fill snapshot that is wrong, or that is taken at the wrong time, corrupts `beat_data` on the first pattern beat. A mode bit that is latched wrongly shows up at once, as lane data leaking into a pattern burst or as beats issued while `lane_valid` is low. The bench follows all of this with a model of its own and compares every output on every clock. Any divergence is therefore reported in the cycle where it first appears.

// File: rtl/wrdata_gen.sv
module wrdata_gen #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 16,
  parameter int CHOP_LEN  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic              cmd_fill,
  input  logic              cmd_chop,
  input  logic [DATA_W-1:0] lane_data,
  input  logic              lane_valid,
  input  logic              fill_we,
  input  logic [7:0]        fill_wdata,
  output logic [7:0]        fill_byte,
  output logic              beat_valid,
  output logic [DATA_W-1:0] beat_data,
  output logic [$clog2(BURST_LEN)-1:0] beat_idx,
  output logic              beat_last,
  output logic              lanes_idle,
  output logic              busy,
  output logic              cmd_reject
);
  localparam int BEAT_W = $clog2(BURST_LEN);
  localparam int LANES  = DATA_W / 8;
  localparam logic [BEAT_W-1:0] FULL_END = BEAT_W'(BURST_LEN - 1);
  localparam logic [BEAT_W-1:0] CHOP_END = BEAT_W'(CHOP_LEN - 1);

  logic              active, fill_mode, chop_mode;
  logic [BEAT_W-1:0] beat;
  logic [7:0]        fill_reg, fill_snap;
  logic              take;

  assign take       = cmd_valid & ~active;
  assign busy       = active;
  assign cmd_reject = cmd_valid & active;
  assign lanes_idle = active & fill_mode;
  assign fill_byte  = fill_reg;
  assign beat_idx   = beat;
  assign beat_valid = active & (fill_mode | lane_valid);
  assign beat_data  = fill_mode ? {LANES{fill_snap}} : lane_data;
  assign beat_last  = beat_valid & (beat == (chop_mode ? CHOP_END : FULL_END));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_reg <= '0;
    end else if (fill_we) begin
      fill_reg <= fill_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      fill_mode <= 1'b0;
      chop_mode <= 1'b0;
      beat      <= '0;
      fill_snap <= '0;
    end else if (take) begin
      active    <= 1'b1;
      fill_mode <= cmd_fill;
      chop_mode <= cmd_chop;
      beat      <= '0;
      fill_snap <= fill_reg;
    end else if (beat_valid) begin
      if (beat_last) begin
        active <= 1'b0;
      end else begin
        beat <= beat + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wrdata_gen_chk.sv
module wrdata_gen_chk #(
  parameter int DATA_W    = 32,
  parameter int BURST_LEN = 16,
  parameter int CHOP_LEN  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              beat_valid,
  input logic [DATA_W-1:0] beat_data,
  input logic [$clog2(BURST_LEN)-1:0] beat_idx,
  input logic              beat_last,
  input logic              lanes_idle,
  input logic              busy,
  input logic              cmd_reject
);
  localparam int LANES = DATA_W / 8;

  assert_end_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |=> !busy);
  assert_step_index_R2: assert property (@(posedge clk) disable iff (!rst_n)
    beat_valid && !beat_last |=> busy && beat_idx == $past(beat_idx) + 1'b1);
  assert_last_index_R3: assert property (@(posedge clk) disable iff (!rst_n)
    beat_last |-> (int'(beat_idx) == CHOP_LEN - 1 || int'(beat_idx) == BURST_LEN - 1));
  assert_hold_on_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !beat_valid |=> busy && $stable(beat_idx));
  assert_fill_replicated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lanes_idle |-> beat_valid && beat_data == {LANES{beat_data[7:0]}});
  assert_fill_steady_R8: assert property (@(posedge clk) disable iff (!rst_n)
    lanes_idle && !beat_last |=> lanes_idle && $stable(beat_data));
  assert_reject_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_reject |-> busy && cmd_valid);
  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !beat_valid && !lanes_idle);
endmodule

bind wrdata_gen wrdata_gen_chk #(.DATA_W(DATA_W), .BURST_LEN(BURST_LEN), .CHOP_LEN(CHOP_LEN)) u_chk (.*);

// File: tb/wrdata_gen_test.sv
module wrdata_gen_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 0, cmd_fill = 0, cmd_chop = 0, lane_valid = 0, fill_we = 0;
  logic [31:0] lane_data = '0;
  logic [7:0]  fill_wdata = '0;
  logic [7:0]  fill_byte;
  logic        beat_valid, beat_last, lanes_idle, busy, cmd_reject;
  logic [31:0] beat_data;
  logic [3:0]  beat_idx;

  always #5 clk = ~clk;

  wrdata_gen uut (.*);

  int checks = 0, fails = 0, cycles = 0, seen = 0;
  bit m_act = 0, m_fill = 0, m_chop = 0;
  int m_beat = 0;
  logic [7:0] m_reg = 0, m_snap = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic cyc(input bit cv, input bit cf, input bit cc, input bit lv,
                     input logic [31:0] ld, input bit we, input logic [7:0] wd);
    bit ev, el;
    cmd_valid = cv; cmd_fill = cf; cmd_chop = cc; lane_valid = lv;
    lane_data = ld; fill_we = we; fill_wdata = wd;
    #2;
    ev = m_act && (m_fill || lv);
    el = ev && (m_beat == (m_chop ? 7 : 15));
    chk(beat_valid == ev, "R4 valid", beat_valid, ev);
    if (ev) begin
      if (m_fill) chk(beat_data == {4{m_snap}}, "R5 data", beat_data, {4{m_snap}});
      else        chk(beat_data == ld, "R4 data", beat_data, ld);
      chk(int'(beat_idx) == m_beat, "R2 index", beat_idx, m_beat);
      seen++;
    end
    chk(beat_last == el, "R3 last", beat_last, el);
    chk(busy == m_act, "R9 busy", busy, m_act);
    chk(lanes_idle == (m_act && m_fill), "R5 idle", lanes_idle, m_act && m_fill);
    chk(cmd_reject == (cv && m_act), "R7 reject", cmd_reject, cv && m_act);
    chk(fill_byte == m_reg, "R8 reg", fill_byte, m_reg);
    @(posedge clk);
    if (!m_act && cv) begin
      m_act = 1; m_fill = cf; m_chop = cc; m_beat = 0; m_snap = m_reg;
    end else if (ev) begin
      if (el) m_act = 0; else m_beat++;
    end
    if (we) m_reg = wd;
    @(negedge clk);
    cycles++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 32'hDEAD_BEEF, 0, 0);
  endtask

  task automatic burst_count(input string req, input int exp);
    chk(seen == exp, req, seen, exp);
    seen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #2;
    chk(!busy && !beat_valid && !beat_last && !lanes_idle && !cmd_reject, "R1 flags",
        {busy, beat_valid, beat_last, lanes_idle, cmd_reject}, 0);
    chk(fill_byte == 8'h00, "R1 fill", fill_byte, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R2/R4: full normal burst with lane gaps
    cyc(1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 24; i++)
      cyc(0, 0, 0, (i % 3) != 1, 32'h1000_0000 + i * 32'h0101, 0, 0);
    idle(2);
    burst_count("R2 full beats", 16);

    // R3: chopped normal burst
    cyc(1, 0, 1, 1, 32'h5555_0000, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, i != 4, 32'hA000_0000 + i, 0, 0);
    idle(2);
    burst_count("R3 chop beats", 8);

    // R8/R5/R6: fill register then full pattern burst; rewrite mid-burst
    cyc(0, 0, 0, 0, 0, 1, 8'hA5);
    cyc(1, 1, 0, 1, 32'hFFFF_FFFF, 0, 0);
    for (int i = 0; i < 16; i++)
      cyc(0, 0, 0, i[0], 32'h0BAD_0000 + i, i == 5, 8'h3C);
    burst_count("R6 pattern full", 16);
    idle(1);

    // R6: chopped pattern with new fill
    cyc(1, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(0, 0, 0, 0, 32'h1234_5678, 0, 0);
    burst_count("R6 pattern chop", 8);
    idle(1);

    // R7: commands while busy, including on the last beat; R9: accept right after
    cyc(1, 1, 1, 0, 0, 0, 0);
    for (int i = 0; i < 8; i++) cyc(1, 0, 0, 1, 32'h7777_0000 + i, 0, 0);
    burst_count("R7 unaffected", 8);
    cyc(1, 0, 1, 1, 32'h8888_0000, 0, 0);
    for (int i = 0; i < 8; i++) cyc(i == 2, 1, 0, 1, 32'h9999_0000 + i, 0, 0);
    idle(2);
    burst_count("R9 back-to-back", 8);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule